// File: doc/BRIEF.md
# Sweep-Capable Vertical Pulse Train Generator

This block drives one vertical clock line for an image sensor. It produces a pulse pattern that repeats. Each period of the pattern begins at a programmed start level. The level flips at up to three programmed positions inside the period. The period length is programmable, and so is the number of periods in a train. The block counts pixel clocks, so it needs no other time base.

A strobe on `region_start_i` opens a region. At that strobe the block captures its configuration and starts a new train. The block has two modes:

- **Normal mode.** The train belongs to one line. The line strobe `hd_i` cuts off any pulses that remain and starts the pattern again from its first element. It does this on every line until the next region opens.
- **Sweep mode.** The line strobe is ignored. The train runs across as many lines as it needs (several thousand pulses over dozens of lines). Then the output rests until a new region opens.

A typical use is a sweep region that clears the vertical registers of a sensor before readout, followed by normal per-line regions.

Top module: `vsp_sweep_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `v_o` and `done_o` are 0 after that edge, and no train runs until a region start.
- R2: If `region_start_i` is high at edge k, the block captures all `cfg_*` inputs and the train restarts at element 0. After edge k+1+n, `v_o` shows the level of element n.
- R3: For element index p inside a period (0 ≤ p < period length), the level is the start polarity XOR the parity of the number of toggle positions that are ≤ p. Two equal positions cancel each other. A position at or above the period length has no effect.
- R4: A train is `cfg_len_i` elements per period times `cfg_rep_i` periods. After the last element, the output goes idle.
- R5: When no train is running, `v_o` equals the captured start polarity. This includes a region programmed with zero repetitions or a zero period length, which never runs a train.
- R6: In normal mode, with a region open and no region start at that edge, an HD edge truncates the train and restarts it at element 0 of period 0. It also restarts a train that has already finished.
- R7: `done_o` is high for the one cycle in which `v_o` shows the final element of a completed train. A train that is cut off by HD or by a region start never raises it. If HD arrives at the same edge as the final element, `done_o` still rises and the train restarts.
- R8: In sweep mode, HD is ignored. The train runs through all its repetitions across line boundaries. It then stays idle until the next region start.
- R9: A region start takes priority over HD at the same edge. A normal region that opens after a sweep region resumes per-line restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hd_i | input | 1 | Line strobe, sampled on the pixel clock |
| region_start_i | input | 1 | Opens a region and captures the configuration |
| cfg_sweep_i | input | 1 | 1 = sweep mode for the region being opened |
| cfg_pol_i | input | 1 | Start polarity of each period |
| cfg_len_i | input | LEN_W (10) | Period length in pixels |
| cfg_rep_i | input | REP_W (12) | Number of periods in a train |
| cfg_tog0_i | input | POS_W (12) | First toggle position |
| cfg_tog1_i | input | POS_W (12) | Second toggle position |
| cfg_tog2_i | input | POS_W (12) | Third toggle position |
| v_o | output | 1 | Vertical clock output (registered) |
| done_o | output | 1 | One-cycle flag at the end of a completed train (registered) |

## Verification
Two events can land on the same edge: the completion of the final element and a line restart. The bench provokes this by setting the HD period equal to the train length, with HD placed exactly on the final element. In normal mode it then expects `done_o` on every line, with the pattern restarted at once. In sweep mode it expects exactly one `done_o`. A region start that coincides with HD is also covered, to check the priority rule. Each outcome is judged two ways: by the cycle index of the first `done_o` and the count of `done_o` pulses, worked out arithmetically, and by a per-cycle comparison against an element-index model.

// File: rtl/vsp_pkg.sv
package vsp_pkg;
  localparam int DEF_POS_W = 12;
  localparam int DEF_LEN_W = 10;
  localparam int DEF_REP_W = 12;
  localparam int NTOG      = 3;
endpackage

// File: rtl/vsp_cfg_regs.sv
module vsp_cfg_regs #(
  parameter int POS_W = vsp_pkg::DEF_POS_W,
  parameter int LEN_W = vsp_pkg::DEF_LEN_W,
  parameter int REP_W = vsp_pkg::DEF_REP_W,
  parameter int NTOG  = vsp_pkg::NTOG
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       capture,
  input  logic                       sweep_d,
  input  logic                       pol_d,
  input  logic [LEN_W-1:0]           len_d,
  input  logic [REP_W-1:0]           rep_d,
  input  logic [NTOG-1:0][POS_W-1:0] tog_d,
  output logic                       open_q,
  output logic                       sweep_q,
  output logic                       pol_q,
  output logic [LEN_W-1:0]           len_q,
  output logic [REP_W-1:0]           rep_q,
  output logic [NTOG-1:0][POS_W-1:0] tog_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      open_q  <= 1'b0;
      sweep_q <= 1'b0;
      pol_q   <= 1'b0;
      len_q   <= '0;
      rep_q   <= '0;
      tog_q   <= '0;
    end else if (capture) begin
      open_q  <= 1'b1;
      sweep_q <= sweep_d;
      pol_q   <= pol_d;
      len_q   <= len_d;
      rep_q   <= rep_d;
      tog_q   <= tog_d;
    end
  end
endmodule

// File: rtl/vsp_pos_counter.sv
module vsp_pos_counter #(
  parameter int LEN_W = vsp_pkg::DEF_LEN_W,
  parameter int REP_W = vsp_pkg::DEF_REP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             load_ok,
  input  logic [LEN_W-1:0] len_q,
  input  logic [REP_W-1:0] rep_q,
  output logic             active,
  output logic [LEN_W-1:0] pix,
  output logic [REP_W-1:0] rep,
  output logic             wrap,
  output logic             fin
);
  localparam logic [LEN_W-1:0] ONE_L = LEN_W'(1);
  localparam logic [REP_W-1:0] ONE_R = REP_W'(1);

  logic last_pix, last_rep;

  assign last_pix = (pix == (len_q - ONE_L));
  assign last_rep = (rep == (rep_q - ONE_R));
  assign wrap     = active & last_pix;
  assign fin      = wrap & last_rep;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      pix    <= '0;
      rep    <= '0;
    end else if (load) begin
      active <= load_ok;
      pix    <= '0;
      rep    <= '0;
    end else if (active) begin
      if (last_pix) begin
        pix <= '0;
        if (last_rep) active <= 1'b0;
        else          rep    <= rep + ONE_R;
      end else begin
        pix <= pix + ONE_L;
      end
    end
  end
endmodule

// File: rtl/vsp_level_shaper.sv
module vsp_level_shaper #(
  parameter int POS_W = vsp_pkg::DEF_POS_W,
  parameter int LEN_W = vsp_pkg::DEF_LEN_W,
  parameter int NTOG  = vsp_pkg::NTOG
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       load,
  input  logic                       load_pol,
  input  logic                       active,
  input  logic                       wrap,
  input  logic                       fin,
  input  logic [LEN_W-1:0]           pix,
  input  logic                       pol_q,
  input  logic [NTOG-1:0][POS_W-1:0] tog_q,
  output logic                       v_o,
  output logic                       done_o
);
  logic [NTOG-1:0] hit_vec;
  logic            phase;
  logic            lvl;

  for (genvar k = 0; k < NTOG; k++) begin : g_cmp
    assign hit_vec[k] = (POS_W'(pix) == tog_q[k]);
  end

  // Level of the current element: running phase flipped by any matching positions
  assign lvl = phase ^ (^hit_vec);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= 1'b0;
      v_o    <= 1'b0;
      done_o <= 1'b0;
    end else begin
      v_o    <= active ? lvl : pol_q;
      done_o <= fin;
      if (load)        phase <= load_pol;
      else if (wrap)   phase <= pol_q;
      else if (active) phase <= lvl;
    end
  end
endmodule

// File: rtl/vsp_sweep_gen.sv
module vsp_sweep_gen #(
  parameter int POS_W = vsp_pkg::DEF_POS_W,
  parameter int LEN_W = vsp_pkg::DEF_LEN_W,
  parameter int REP_W = vsp_pkg::DEF_REP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hd_i,
  input  logic             region_start_i,
  input  logic             cfg_sweep_i,
  input  logic             cfg_pol_i,
  input  logic [LEN_W-1:0] cfg_len_i,
  input  logic [REP_W-1:0] cfg_rep_i,
  input  logic [POS_W-1:0] cfg_tog0_i,
  input  logic [POS_W-1:0] cfg_tog1_i,
  input  logic [POS_W-1:0] cfg_tog2_i,
  output logic             v_o,
  output logic             done_o
);
  localparam int NTOG = vsp_pkg::NTOG;

  logic                       open_q, sweep_q, pol_q;
  logic [LEN_W-1:0]           len_q;
  logic [REP_W-1:0]           rep_q;
  logic [NTOG-1:0][POS_W-1:0] tog_q;
  logic                       load, load_ok, load_pol;
  logic                       cnt_active, cnt_wrap, cnt_fin;
  logic [LEN_W-1:0]           cnt_pix;
  logic [REP_W-1:0]           cnt_rep;

  vsp_cfg_regs #(.POS_W(POS_W), .LEN_W(LEN_W), .REP_W(REP_W), .NTOG(NTOG)) cfg_i (
    .clk     (clk),
    .rst     (rst),
    .capture (region_start_i),
    .sweep_d (cfg_sweep_i),
    .pol_d   (cfg_pol_i),
    .len_d   (cfg_len_i),
    .rep_d   (cfg_rep_i),
    .tog_d   ({cfg_tog2_i, cfg_tog1_i, cfg_tog0_i}),
    .open_q  (open_q),
    .sweep_q (sweep_q),
    .pol_q   (pol_q),
    .len_q   (len_q),
    .rep_q   (rep_q),
    .tog_q   (tog_q)
  );

  // Region start wins; HD restarts only an open normal-mode region
  always_comb begin
    load     = region_start_i | (hd_i & open_q & ~sweep_q);
    load_ok  = region_start_i ? ((cfg_rep_i != '0) && (cfg_len_i != '0))
                              : ((rep_q != '0) && (len_q != '0));
    load_pol = region_start_i ? cfg_pol_i : pol_q;
  end

  vsp_pos_counter #(.LEN_W(LEN_W), .REP_W(REP_W)) cnt_i (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .load_ok (load_ok),
    .len_q   (len_q),
    .rep_q   (rep_q),
    .active  (cnt_active),
    .pix     (cnt_pix),
    .rep     (cnt_rep),
    .wrap    (cnt_wrap),
    .fin     (cnt_fin)
  );

  vsp_level_shaper #(.POS_W(POS_W), .LEN_W(LEN_W), .NTOG(NTOG)) shp_i (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_pol (load_pol),
    .active   (cnt_active),
    .wrap     (cnt_wrap),
    .fin      (cnt_fin),
    .pix      (cnt_pix),
    .pol_q    (pol_q),
    .tog_q    (tog_q),
    .v_o      (v_o),
    .done_o   (done_o)
  );
endmodule

// File: rtl/vsp_sweep_gen_chk.sv
module vsp_sweep_gen_chk #(
  parameter int LEN_W = vsp_pkg::DEF_LEN_W,
  parameter int REP_W = vsp_pkg::DEF_REP_W
) (
  input logic             clk,
  input logic             rst,
  input logic             hd_i,
  input logic             region_start_i,
  input logic             v_o,
  input logic             done_o,
  input logic             act,
  input logic [LEN_W-1:0] pix,
  input logic [REP_W-1:0] rep,
  input logic             wrap,
  input logic             open_q,
  input logic             sweep_q,
  input logic             pol_q,
  input logic [LEN_W-1:0] len_q
);
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!v_o && !done_o && !act));

  a_r4_pix_in_range: assert property (@(posedge clk) disable iff (rst)
    act |-> (pix < len_q));

  a_r5_idle_holds_pol: assert property (@(posedge clk) disable iff (rst)
    !act |=> (v_o == $past(pol_q)));

  a_r6_hd_restarts_normal: assert property (@(posedge clk) disable iff (rst)
    (open_q && !sweep_q && hd_i && !region_start_i) |=> (pix == '0 && rep == '0));

  a_r7_done_after_wrap: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(act && wrap));

  a_r8_sweep_ignores_hd: assert property (@(posedge clk) disable iff (rst)
    (act && sweep_q && hd_i && !region_start_i && !wrap) |=> (pix == $past(pix) + 1'b1));

  a_r9_start_restarts: assert property (@(posedge clk) disable iff (rst)
    region_start_i |=> (pix == '0 && rep == '0 && open_q));
endmodule

bind vsp_sweep_gen vsp_sweep_gen_chk #(.LEN_W(LEN_W), .REP_W(REP_W)) chk_i (
  .clk            (clk),
  .rst            (rst),
  .hd_i           (hd_i),
  .region_start_i (region_start_i),
  .v_o            (v_o),
  .done_o         (done_o),
  .act            (cnt_active),
  .pix            (cnt_pix),
  .rep            (cnt_rep),
  .wrap           (cnt_wrap),
  .open_q         (open_q),
  .sweep_q        (sweep_q),
  .pol_q          (pol_q),
  .len_q          (len_q)
);

// File: tb/vsp_sweep_gen_tb.sv
`timescale 1ns/1ps
module vsp_sweep_gen_tb_top;
  localparam int POS_W = 12;
  localparam int LEN_W = 10;
  localparam int REP_W = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hd = 1'b0, rs = 1'b0, sw = 1'b0, pol = 1'b0;
  logic [LEN_W-1:0] len = '0;
  logic [REP_W-1:0] rep = '0;
  logic [POS_W-1:0] t0 = '0, t1 = '0, t2 = '0;
  logic v, done;

  always #2 clk = ~clk;

  vsp_sweep_gen #(.POS_W(POS_W), .LEN_W(LEN_W), .REP_W(REP_W)) dut_i (
    .clk(clk), .rst(rst), .hd_i(hd), .region_start_i(rs),
    .cfg_sweep_i(sw), .cfg_pol_i(pol), .cfg_len_i(len), .cfg_rep_i(rep),
    .cfg_tog0_i(t0), .cfg_tog1_i(t1), .cfg_tog2_i(t2),
    .v_o(v), .done_o(done)
  );

  int    checks = 0;
  int    fails  = 0;
  string cur_req = "R1";
  bit    chk_en = 1'b0;

  task automatic chk(bit ok, string what, int actual, int expected);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, actual, expected);
    end
  endtask

  // Element-index reference model
  bit m_open, m_act, m_sweep, m_pol, exp_v, exp_d;
  int m_len, m_rep, m_n;
  int m_t[3];

  function automatic bit level_of(int p);
    int c;
    c = 0;
    for (int k = 0; k < 3; k++) if (m_t[k] <= p) c++;
    return m_pol ^ c[0];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_open = 0; m_act = 0; m_sweep = 0; m_pol = 0;
      m_len = 0; m_rep = 0; m_n = 0; exp_v = 0; exp_d = 0;
    end else begin
      exp_d = m_act && (m_n == m_len * m_rep - 1);
      exp_v = m_act ? level_of(m_n % m_len) : m_pol;
      if (rs) begin
        m_sweep = sw; m_pol = pol; m_len = int'(len); m_rep = int'(rep);
        m_t[0] = int'(t0); m_t[1] = int'(t1); m_t[2] = int'(t2);
        m_open = 1; m_act = (m_len != 0) && (m_rep != 0); m_n = 0;
      end else if (hd && m_open && !m_sweep) begin
        m_act = (m_len != 0) && (m_rep != 0); m_n = 0;
      end else if (m_act) begin
        if (m_n == m_len * m_rep - 1) m_act = 0;
        else m_n++;
      end
    end
  end

  always @(negedge clk) begin
    if (chk_en) begin
      chk(v == exp_v, "v_o per-cycle", int'(v), int'(exp_v));
      chk(done == exp_d, "done_o per-cycle", int'(done), int'(exp_d));
    end
  end

  task automatic start_region(bit s, bit p, int l, int r, int a, int b, int c, bit with_hd);
    @(negedge clk);
    sw = s; pol = p; len = LEN_W'(l); rep = REP_W'(r);
    t0 = POS_W'(a); t1 = POS_W'(b); t2 = POS_W'(c);
    rs = 1'b1; hd = with_hd;
    @(negedge clk);
    rs = 1'b0; hd = 1'b0;
  endtask

  task automatic run(int n, int per, int ph, output int first_done, output int ndone);
    first_done = -1;
    ndone = 0;
    for (int i = 0; i < n; i++) begin
      hd = (per > 0) && ((i % per) == ph);
      @(negedge clk);
      if (done) begin
        if (ndone == 0) first_done = i;
        ndone++;
      end
    end
    hd = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int fd, nd;
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk(v == 1'b0, "reset v_o", int'(v), 0);
    chk(done == 1'b0, "reset done_o", int'(done), 0);
    rst = 1'b0;
    chk_en = 1'b1;
    run(10, 5, 0, fd, nd);
    chk(nd == 0, "no train before region start", nd, 0);

    // Normal mode, train fits in the line (R2, R4, R6)
    cur_req = "R2";
    start_region(0, 0, 8, 3, 1, 3, 6, 0);
    run(100, 37, 30, fd, nd);
    cur_req = "R4";
    chk(fd == 23, "first done index", fd, 23);
    chk(nd == 3, "done count with line restarts", nd, 3);

    // Normal mode, train longer than the line: truncated (R6, R7)
    cur_req = "R6";
    start_region(0, 1, 10, 6, 2, 2, 9, 0);
    run(120, 37, 30, fd, nd);
    cur_req = "R7";
    chk(nd == 0, "no done on truncation", nd, 0);

    // Toggle positions at or above the period length (R3)
    cur_req = "R3";
    start_region(0, 0, 5, 4, 7, 4095, 0, 0);
    run(40, 0, 0, fd, nd);
    chk(fd == 19, "first done index", fd, 19);
    chk(nd == 1, "done count", nd, 1);

    // Sweep across many lines (R8)
    cur_req = "R8";
    start_region(1, 1, 6, 40, 0, 3, 5, 0);
    run(300, 37, 5, fd, nd);
    chk(fd == 239, "sweep done index across lines", fd, 239);
    chk(nd == 1, "sweep single done", nd, 1);

    // Empty programs idle at polarity (R5)
    cur_req = "R5";
    start_region(0, 1, 7, 0, 1, 2, 3, 0);
    run(60, 37, 3, fd, nd);
    chk(nd == 0, "zero repetitions no done", nd, 0);
    chk(v == 1'b1, "zero repetitions idle level", int'(v), 1);
    start_region(0, 0, 0, 5, 1, 2, 3, 0);
    run(60, 37, 3, fd, nd);
    chk(nd == 0, "zero length no done", nd, 0);
    chk(v == 1'b0, "zero length idle level", int'(v), 0);

    // Region start together with HD, then sweep followed by normal (R9)
    cur_req = "R9";
    start_region(0, 1, 6, 2, 0, 2, 4, 1);
    run(40, 0, 0, fd, nd);
    chk(fd == 11, "start wins over hd", fd, 11);
    start_region(1, 0, 4, 30, 1, 2, 3, 0);
    run(150, 37, 0, fd, nd);
    chk(fd == 119, "sweep before normal", fd, 119);
    start_region(0, 1, 4, 2, 0, 1, 2, 0);
    run(80, 37, 10, fd, nd);
    chk(fd == 7, "normal after sweep first done", fd, 7);
    chk(nd == 3, "normal after sweep resumes per line", nd, 3);

    // HD on the same edge as the final element (R7 with R6 / R8)
    cur_req = "R7";
    start_region(0, 0, 4, 2, 0, 1, 3, 0);
    run(40, 8, 7, fd, nd);
    chk(fd == 7, "coincident hd first done", fd, 7);
    chk(nd == 5, "coincident hd done every line", nd, 5);
    cur_req = "R8";
    start_region(1, 0, 4, 2, 0, 1, 3, 0);
    run(40, 8, 7, fd, nd);
    chk(fd == 7, "sweep coincident hd done", fd, 7);
    chk(nd == 1, "sweep coincident hd single done", nd, 1);

    chk_en = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule